// File: doc/BRIEF.md
# Halt-Triggered Power Mode Controller

This block decides which low-power state the chip enters when the processor core reports that it has executed a halt. The core sends a one-cycle halt strobe. On that cycle the block samples two configuration bits and the enable states of the watchdog and the low-voltage detector. The first bit allows an idle state. The second bit keeps the main clock running. From these values the block picks one of four halt modes.

Each mode gates the main system clock and the low-speed sub clock in its own way. The enables for both clocks are registered, so each one changes cleanly, one cycle after the event that caused the change.

When the block enters a halt mode, it does the following:
- It sends the watchdog a one-cycle clear pulse.
- It sets a power-down flag.
- It clears the watchdog time-out flag.
- It raises a stall output that holds the core at the halt.

A wake-up event returns the block to run mode. A watchdog time-out that arrives during a halt mode also returns it to run mode and sets the time-out flag. The power-down flag stays set until software clears it. The block drives no reset or clear to registers or I/O, so their contents survive every halt mode.

Top module: `pwr_halt_ctrl`

## Requirements
- R1: After a synchronous reset: mode code 0 (run), both clock enables 1, power-down flag 0, time-out flag 0, stall 0, watchdog clear 0.
- R2: A halt taken with the idle bit at 0 and the watchdog or the voltage detector enabled gives mode code 2 (light sleep) one cycle later. The system clock enable is then 0 and the sub clock enable is 1.
- R3: A halt taken with the idle bit at 0 and both the watchdog and the voltage detector disabled gives mode code 1 (deep sleep). Both clock enables are then 0.
- R4: A halt taken with the idle bit at 1 and the keep-clock bit at 0 gives mode code 3 (idle, main clock off). The system clock enable is 0 and the sub clock enable is 1.
- R5: A halt taken with the idle bit at 1 and the keep-clock bit at 1 gives mode code 4 (idle, main clock on). Both clock enables are 1.
- R6: In the cycle after a halt is accepted, the watchdog clear output is 1 for exactly one cycle. In that same cycle the power-down flag becomes 1 and the time-out flag becomes 0.
- R7: The stall output is 1 exactly while the mode code is not 0.
- R8: A wake-up event in any halt mode gives the following one cycle later:
  - mode code 0;
  - both clock enables 1;
  - stall 0.

  The power-down flag stays at 1.
- R9: A watchdog time-out sets the time-out flag one cycle later. During a halt mode it also wakes the block, exactly as in R8. A time-out in the same cycle as a halt strobe makes the block ignore the halt.
- R10: A software clear of the power-down flag takes effect one cycle later. A halt accepted in the same cycle takes priority, and the flag stays 1.
- R11: A halt strobe during a halt mode is ignored: the mode does not change and no clear pulse is sent. A wake-up event during run mode is also ignored.
- R12: The configuration bits and the detector enables are sampled only on the halt cycle. Changing them during a halt mode does not change the mode code or the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_i | input | 1 | One-cycle halt strobe from the core |
| idle_en_i | input | 1 | Allows an idle mode instead of a sleep mode |
| keep_sys_i | input | 1 | Keeps the system clock on during idle |
| wdt_en_i | input | 1 | Watchdog enabled |
| lvd_en_i | input | 1 | Voltage detector enabled |
| wake_i | input | 1 | Wake-up event |
| wdt_tmo_i | input | 1 | Watchdog time-out strobe |
| pdf_clr_i | input | 1 | Software clear of the power-down flag |
| sys_clk_en_o | output | 1 | Registered system clock enable |
| sub_clk_en_o | output | 1 | Registered sub clock enable |
| mode_o | output | 3 | Current mode code |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |
| wdt_clr_o | output | 1 | One-cycle watchdog counter clear |
| stall_o | output | 1 | Holds the core at the halt |

## Verification
The bench takes a halt under each of the four configurations and checks that each picks its own mode code and clock pair. A design that confused deep sleep with light sleep would leave the sub clock running, or would stop it while the watchdog still needs it.

The bench also changes the configuration and strobes halt again while the block is halted. A design that resampled its inputs would switch modes in the middle of a halt, or would send a second clear pulse.

Several collisions are driven on the same cycle:
- a time-out with a halt, which must leave the block in run mode with the time-out flag set;
- a software flag clear with a halt, which must leave the power-down flag set;
- a wake-up while in run mode, which must do nothing.

// File: rtl/pwr_halt_pkg.sv
// Shared types for the halt power-mode controller.
// Assumes: the mode code width is 3 bits; the codes are fixed, because software reads them.
package pwr_halt_pkg;

    localparam int MODE_W  = 3;
    localparam int NCLK    = 2;
    localparam int SYS_IDX = 0;
    localparam int SUB_IDX = 1;

    typedef enum logic [MODE_W-1:0] {
        PM_RUN    = 3'd0,
        PM_DEEP   = 3'd1,
        PM_LIGHT  = 3'd2,
        PM_IDLE_S = 3'd3,
        PM_IDLE_F = 3'd4
    } pm_mode_t;

    // Reports whether clock domain idx runs in mode m.
    function automatic logic clk_runs(pm_mode_t m, int idx);
        logic on;
        if (idx == SYS_IDX) begin
            on = (m == PM_RUN) || (m == PM_IDLE_F);
        end else begin
            on = (m != PM_DEEP);
        end
        return on;
    endfunction

endpackage

// File: rtl/pwr_mode_pick.sv
// Picks the halt mode from the configuration bits and the detector enables.
// Assumes: the result is used only on the cycle in which a halt is accepted.
module pwr_mode_pick
    import pwr_halt_pkg::*;
(
    input  logic     idle_en_i,
    input  logic     keep_sys_i,
    input  logic     wdt_en_i,
    input  logic     lvd_en_i,
    output pm_mode_t pick_o
);

    // Choose among the four halt modes.
    always_comb begin
        if (idle_en_i) begin
            pick_o = keep_sys_i ? PM_IDLE_F : PM_IDLE_S;
        end else if (wdt_en_i || lvd_en_i) begin
            pick_o = PM_LIGHT;
        end else begin
            pick_o = PM_DEEP;
        end
    end

    always_comb begin
        AST_PICK_NOT_RUN: assert (pick_o != PM_RUN); // R2
    end

endmodule

// File: rtl/pwr_seq.sv
// Sequences between run mode and the halt modes. Accepts a halt only in run mode,
// and only when no time-out arrives on the same cycle. Returns to run on a wake-up
// or a time-out.
// Assumes: halt_i, wake_i and tmo_i are synchronous to clk.
module pwr_seq
    import pwr_halt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     halt_i,
    input  logic     wake_i,
    input  logic     tmo_i,
    input  pm_mode_t pick_i,
    output pm_mode_t mode_o,
    output pm_mode_t mode_nxt_o,
    output logic     accept_o,
    output logic     wdt_clr_o,
    output logic     stall_o
);

    pm_mode_t mode_q;
    logic     leave;
    logic     clr_q;
    logic     stall_q;

    // Qualify halt acceptance and wake-up against the current mode.
    always_comb begin
        accept_o = halt_i && (mode_q == PM_RUN) && !tmo_i;
        leave    = (wake_i || tmo_i) && (mode_q != PM_RUN);
    end

    // Next-mode selection.
    always_comb begin
        if (accept_o) begin
            mode_nxt_o = pick_i;
        end else if (leave) begin
            mode_nxt_o = PM_RUN;
        end else begin
            mode_nxt_o = mode_q;
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_RUN;
        end else begin
            mode_q <= mode_nxt_o;
        end
    end

    // Registered clear pulse and stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q   <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            clr_q   <= accept_o;
            stall_q <= (mode_nxt_o != PM_RUN);
        end
    end

    assign mode_o    = mode_q;
    assign wdt_clr_o = clr_q;
    assign stall_o   = stall_q;

    AST_STALL_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q == (mode_q != PM_RUN)); // R7
    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !clr_q); // R6
    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PM_RUN && wake_i) |=> mode_q == PM_RUN); // R8
    AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PM_RUN && !wake_i && !tmo_i) |=> $stable(mode_q)); // R11

endmodule

// File: rtl/pwr_clk_gate.sv
// Registers one clock enable per domain, driven by the next mode. Each enable
// therefore changes one cycle after the halt or wake-up that causes the change.
// Assumes: the enables drive clock-gating cells that latch them while the
// gated clock is low.
module pwr_clk_gate
    import pwr_halt_pkg::*;
#(
    parameter int N = NCLK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pm_mode_t     mode_nxt_i,
    input  pm_mode_t     mode_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    for (genvar g = 0; g < N; g++) begin : g_dom
        // Enable register for domain g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g] <= 1'b1;
            end else begin
                en_q[g] <= clk_runs(mode_nxt_i, g);
            end
        end
    end

    assign en_o = en_q;

    AST_SYS_OFF_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PM_DEEP || mode_i == PM_LIGHT || mode_i == PM_IDLE_S) |-> !en_q[SYS_IDX]); // R4
    AST_DEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PM_DEEP) |-> en_q == '0); // R3
    AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PM_RUN || mode_i == PM_IDLE_F) |-> en_q[SYS_IDX]); // R5

endmodule

// File: rtl/pwr_flags.sv
// Power-down and time-out status flags. A halt sets power-down and clears time-out.
// A time-out sets time-out. Software clears power-down; a halt on the same cycle wins.
// Assumes: the controller does not accept a halt on a cycle with a time-out.
module pwr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic tmo_i,
    input  logic pdf_clr_i,
    output logic pdf_o,
    output logic to_o
);

    logic pdf_q;
    logic to_q;

    // Power-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdf_q <= 1'b0;
        end else if (accept_i) begin
            pdf_q <= 1'b1;
        end else if (pdf_clr_i) begin
            pdf_q <= 1'b0;
        end
    end

    // Time-out flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q <= 1'b0;
        end else if (tmo_i) begin
            to_q <= 1'b1;
        end else if (accept_i) begin
            to_q <= 1'b0;
        end
    end

    assign pdf_o = pdf_q;
    assign to_o  = to_q;

    AST_HALT_SETS_PDF: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> (pdf_q && !to_q)); // R6
    AST_TMO_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_i |=> to_q); // R9
    AST_PDF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pdf_clr_i && !accept_i) |=> !pdf_q); // R10

endmodule

// File: rtl/pwr_halt_ctrl.sv
// Top of the halt power-mode controller. Connects the mode picker, the sequencer,
// the clock-enable registers and the status flags.
// Assumes: clk is always on and is not one of the clocks this block gates.
module pwr_halt_ctrl
    import pwr_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              idle_en_i,
    input  logic              keep_sys_i,
    input  logic              wdt_en_i,
    input  logic              lvd_en_i,
    input  logic              wake_i,
    input  logic              wdt_tmo_i,
    input  logic              pdf_clr_i,
    output logic              sys_clk_en_o,
    output logic              sub_clk_en_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              pdf_o,
    output logic              to_o,
    output logic              wdt_clr_o,
    output logic              stall_o
);

    pm_mode_t        pick;
    pm_mode_t        mode;
    pm_mode_t        mode_nxt;
    logic            accept;
    logic [NCLK-1:0] en;

    pwr_mode_pick u_pick (
        .idle_en_i  (idle_en_i),
        .keep_sys_i (keep_sys_i),
        .wdt_en_i   (wdt_en_i),
        .lvd_en_i   (lvd_en_i),
        .pick_o     (pick)
    );

    pwr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_i     (halt_i),
        .wake_i     (wake_i),
        .tmo_i      (wdt_tmo_i),
        .pick_i     (pick),
        .mode_o     (mode),
        .mode_nxt_o (mode_nxt),
        .accept_o   (accept),
        .wdt_clr_o  (wdt_clr_o),
        .stall_o    (stall_o)
    );

    pwr_clk_gate #(.N(NCLK)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_nxt_i (mode_nxt),
        .mode_i     (mode),
        .en_o       (en)
    );

    pwr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .tmo_i     (wdt_tmo_i),
        .pdf_clr_i (pdf_clr_i),
        .pdf_o     (pdf_o),
        .to_o      (to_o)
    );

    assign sys_clk_en_o = en[SYS_IDX];
    assign sub_clk_en_o = en[SUB_IDX];
    assign mode_o       = mode;

    AST_LIGHT_SUB_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_LIGHT) |-> (sub_clk_en_o && !sys_clk_en_o)); // R2
    AST_CFG_IGNORED_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_RUN && !wake_i && !wdt_tmo_i) |=> ($stable(sys_clk_en_o) && $stable(sub_clk_en_o))); // R12

endmodule

// File: tb/sim_pwr_halt_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_halt_ctrl;

    typedef struct {
        logic [2:0] mode;
        logic       sys;
        logic       sub;
        logic       pdf;
        logic       to;
        logic       clr;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, halt, idle, keep, wdt, lvd, wake, tmo, pclr;
    logic sys_en, sub_en, pdf, to, clr, stall;
    logic [2:0] mode;
    int   tcnt = 0;
    int   fcnt = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    pwr_halt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .idle_en_i(idle), .keep_sys_i(keep),
        .wdt_en_i(wdt), .lvd_en_i(lvd), .wake_i(wake), .wdt_tmo_i(tmo), .pdf_clr_i(pclr),
        .sys_clk_en_o(sys_en), .sub_clk_en_o(sub_en), .mode_o(mode), .pdf_o(pdf),
        .to_o(to), .wdt_clr_o(clr), .stall_o(stall)
    );

    // Driver: sets the inputs for one cycle and queues the result expected after the next edge.
    task automatic apply(input logic r, input logic h, input logic i, input logic k,
                         input logic w, input logic l, input logic wk, input logic t,
                         input logic pc, input logic [2:0] em, input logic es, input logic eb,
                         input logic ep, input logic et, input logic ec, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r; halt = h; idle = i; keep = k; wdt = w; lvd = l;
        wake = wk; tmo = t; pclr = pc;
        e.mode = em; e.sys = es; e.sub = eb; e.pdf = ep; e.to = et; e.clr = ec; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tcnt++;
        if (act != exp) begin
            fcnt++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compares outputs just after each edge with the oldest queued item.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "mode",  int'(mode),   int'(e.mode));
            chk(e.tag, "sys",   int'(sys_en), int'(e.sys));
            chk(e.tag, "sub",   int'(sub_en), int'(e.sub));
            chk(e.tag, "pdf",   int'(pdf),    int'(e.pdf));
            chk(e.tag, "to",    int'(to),     int'(e.to));
            chk(e.tag, "clr",   int'(clr),    int'(e.clr));
            chk({e.tag, "/R7"}, "stall", int'(stall), int'(e.mode != 3'd0));
        end
    end

    initial begin
        #(8 * 100000);
        fcnt++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", tcnt, fcnt);
        $finish;
    end

    initial begin
        //     r h i k w l wk t pc  mode sys sub pdf to clr
        apply(0,0,0,0,0,0,0,0,0, 3'd0,1,1,0,0,0, "R1 reset");
        apply(1,0,0,0,0,0,0,0,0, 3'd0,1,1,0,0,0, "R1 run idle");
        apply(1,1,0,0,1,0,0,0,0, 3'd2,0,1,1,0,1, "R2/R6 light sleep via wdt");
        apply(1,0,0,0,1,0,0,0,0, 3'd2,0,1,1,0,0, "R6 pulse ends");
        apply(1,1,1,1,0,0,0,0,0, 3'd2,0,1,1,0,0, "R11/R12 halt+cfg in halt");
        apply(1,0,1,1,0,0,0,0,0, 3'd2,0,1,1,0,0, "R12 cfg held");
        apply(1,0,0,0,0,0,1,0,0, 3'd0,1,1,1,0,0, "R8 wake");
        apply(1,0,0,0,0,0,1,0,0, 3'd0,1,1,1,0,0, "R11 wake in run");
        apply(1,0,0,0,0,0,0,0,1, 3'd0,1,1,0,0,0, "R10 pdf clear");
        apply(1,1,0,0,0,0,0,0,0, 3'd1,0,0,1,0,1, "R3 deep sleep");
        apply(1,0,0,0,0,0,0,0,0, 3'd1,0,0,1,0,0, "R3 deep held");
        apply(1,0,0,0,0,0,0,1,0, 3'd0,1,1,1,1,0, "R9 timeout wakes");
        apply(1,1,1,0,0,0,0,0,0, 3'd3,0,1,1,0,1, "R4/R6 idle slow, to cleared");
        apply(1,0,0,0,0,0,1,0,0, 3'd0,1,1,1,0,0, "R8 wake from idle slow");
        apply(1,1,1,1,0,0,0,0,0, 3'd4,1,1,1,0,1, "R5 idle fast");
        apply(1,0,0,0,0,0,0,0,0, 3'd4,1,1,1,0,0, "R5 idle fast held");
        apply(1,0,0,0,0,0,1,0,0, 3'd0,1,1,1,0,0, "R8 wake from idle fast");
        apply(1,1,0,0,0,1,0,0,1, 3'd2,0,1,1,0,1, "R10/R2 halt beats clear via lvd");
        apply(1,0,0,0,0,0,1,0,0, 3'd0,1,1,1,0,0, "R8 wake, pdf kept");
        apply(1,1,1,1,0,0,0,1,0, 3'd0,1,1,1,1,0, "R9 timeout blocks halt");
        apply(1,1,0,0,0,1,0,0,0, 3'd2,0,1,1,0,1, "R6 halt clears to");
        apply(0,0,0,0,0,0,0,0,0, 3'd0,1,1,0,0,0, "R1 reset from halt");
        apply(1,0,0,0,0,0,0,0,0, 3'd0,1,1,0,0,0, "R1 after reset");
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", tcnt, fcnt);
        $finish;
    end

endmodule